// File: doc/BRIEF.md
# Shifted-Operand Logic Unit

This block is the data-processing stage of a simple processor pipeline. Each cycle it takes a first operand and builds a second operand from one of two sources. The first source is a register value fed through an inline barrel shifter. The second is a compact immediate field, made of a small value and a rotation count. It applies one of eight logical or arithmetic operations to the two operands. The outputs are a registered result, a result-write enable and four condition flags: negative, zero, carry and overflow.

Compare and test operations exist only to set flags, so they never request a register write. Flags change only when the caller asks for it or when the operation is a compare or test. Otherwise the flag outputs keep their previous values, and the shifter uses that held carry when a shift moves no bits. All outputs appear on the clock edge after the inputs are presented.

Top module: `sol_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result`, `result_we` and all four flags become 0.
- R2: Outputs are registered: inputs present before edge k show up on the outputs after edge k. Opcodes are 0 AND, 1 OR, 2 XOR, 3 bit-clear (first AND NOT second), 4 ADD, 5 SUB, 6 CMP, 7 TST. Bit-clear of 0xFF with 0xAA gives 0x55.
- R3: With `use_imm` = 0, the second operand is `src_b` shifted by `shift_amt`. `shift_kind` selects the shift: 0 logical left, 1 logical right with zero fill, 2 arithmetic right with sign fill, 3 rotate right. An amount of 0 passes `src_b` through unchanged.
- R4: Bits shifted past either end are lost. Shifting 4 right logically by 2, then shifting that result right by 3, gives 0.
- R5: With `use_imm` = 1, `imm_field` bits [IMM_W-1:0] are zero-extended and rotated right by twice the field in the top ROT_W bits, modulo DATA_W. That rotated value is the second operand.
- R6: ADD yields first plus second operand, and SUB and CMP yield first minus second, all modulo 2^DATA_W.
- R7: `result_we` is 0 after CMP and TST and 1 after every other opcode. `result` still carries the computed value in both cases.
- R8: Flags load only when `set_flags` is 1 or the opcode is CMP or TST. Otherwise all four flags hold.
- R9: When flags load, N equals the result's top bit and Z is 1 exactly when the result is zero.
- R10: For AND, OR, XOR, bit-clear and TST, C takes the last bit shifted out, or the held C when the shift amount is 0. For an immediate, C is the held C when the rotate field is 0 and otherwise the immediate's top bit. V holds.
- R11: For ADD, C is the adder carry-out. For SUB and CMP, C is 1 when no borrow occurs. For all three, V is the signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Register value for the second operand |
| use_imm | input | 1 | 1 selects the rotated immediate as second operand |
| shift_kind | input | 2 | Shift type applied to `src_b` |
| shift_amt | input | clog2(DATA_W) | Shift distance |
| imm_field | input | IMM_W+ROT_W | Rotate count (top) and value (bottom) |
| op_code | input | 3 | Operation select |
| set_flags | input | 1 | Request a flag update |
| result | output | DATA_W | Registered result |
| result_we | output | 1 | Registered result-write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench instantiates the unit with DATA_W = 8, which gives a shift amount of 3 bits, while IMM_W = 8 and ROT_W = 4 keep their default widths. At this width every opcode, shift type and shift amount can be swept together with both settings of `set_flags`, against operand pairs chosen to hit sign changes, carries and overflows. The width is also small enough to try all 4096 immediate fields. The rotate counts then wrap the byte several times, and the narrow operands make the carry and overflow cases easy to reach.

// File: rtl/sol_pkg.sv
`timescale 1ns/1ps
package sol_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_ORR = 3'd1,
    OP_EOR = 3'd2,
    OP_BIC = 3'd3,
    OP_ADD = 3'd4,
    OP_SUB = 3'd5,
    OP_CMP = 3'd6,
    OP_TST = 3'd7
  } sol_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sol_shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } sol_flags_t;

  // Opcodes that only probe operands: flags yes, register write no
  function automatic logic op_is_probe(sol_op_e o);
    return (o == OP_CMP) || (o == OP_TST);
  endfunction

  // Opcodes whose C and V come from the adder
  function automatic logic op_is_arith(sol_op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_CMP);
  endfunction

endpackage

// File: rtl/sol_shifter.sv
`timescale 1ns/1ps
module sol_shifter
  import sol_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  din,
  input  sol_shift_e    kind,
  input  logic [SW-1:0] amt,
  input  logic          c_in,
  output logic [W-1:0]  dout,
  output logic          c_out
);

  logic [W:0]     wide;
  logic [2*W-1:0] dbl;

  always_comb begin
    wide  = '0;
    dbl   = '0;
    dout  = din;
    c_out = c_in;
    if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin
          // extra bit on top catches the last bit pushed out
          wide  = {1'b0, din} << amt;
          dout  = wide[W-1:0];
          c_out = wide[W];
        end
        SH_LSR: begin
          wide  = {din, 1'b0} >> amt;
          dout  = wide[W:1];
          c_out = wide[0];
        end
        SH_ASR: begin
          wide  = $signed({din, 1'b0}) >>> amt;
          dout  = wide[W:1];
          c_out = wide[0];
        end
        SH_ROR: begin
          dbl   = {din, din} >> amt;
          dout  = dbl[W-1:0];
          c_out = dbl[W-1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sol_imm_expand.sv
`timescale 1ns/1ps
module sol_imm_expand #(
  parameter int W  = 32,
  parameter int IW = 8,
  parameter int RW = 4,
  parameter int SW = 5
) (
  input  logic [IW+RW-1:0] field,
  input  logic             c_in,
  output logic [W-1:0]     value,
  output logic             c_out
);

  logic [RW-1:0]  rot;
  logic [SW-1:0]  rot_amt;
  logic [W-1:0]   base;
  logic [2*W-1:0] dbl;

  always_comb begin
    rot     = field[IW+RW-1:IW];
    base    = W'(field[IW-1:0]);
    rot_amt = SW'((int'(rot) * 2) % W);
    dbl     = {base, base} >> rot_amt;
    value   = dbl[W-1:0];
    c_out   = (rot == '0) ? c_in : value[W-1];
  end

endmodule

// File: rtl/sol_alu.sv
`timescale 1ns/1ps
module sol_alu
  import sol_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  sol_op_e      op,
  input  logic         sh_c,
  input  sol_flags_t   f_in,
  output logic [W-1:0] res,
  output sol_flags_t   f_out
);

  logic         subtract;
  logic [W-1:0] b_add;
  logic [W:0]   sum;

  always_comb begin
    subtract = (op == OP_SUB) || (op == OP_CMP);
    b_add    = subtract ? ~b : b;
    sum      = {1'b0, a} + {1'b0, b_add} + (W+1)'(subtract);
    unique case (op)
      OP_AND, OP_TST: res = a & b;
      OP_ORR:         res = a | b;
      OP_EOR:         res = a ^ b;
      OP_BIC:         res = a & ~b;
      default:        res = sum[W-1:0];
    endcase
    f_out.n = res[W-1];
    f_out.z = (res == '0);
    if (op_is_arith(op)) begin
      f_out.c = sum[W];
      f_out.v = (a[W-1] == b_add[W-1]) && (res[W-1] != a[W-1]);
    end else begin
      f_out.c = sh_c;
      f_out.v = f_in.v;
    end
  end

endmodule

// File: rtl/sol_unit.sv
`timescale 1ns/1ps
module sol_unit
  import sol_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int SHAMT_W = $clog2(DATA_W),
  localparam int FIELD_W = IMM_W + ROT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  src_a,
  input  logic [DATA_W-1:0]  src_b,
  input  logic               use_imm,
  input  logic [1:0]         shift_kind,
  input  logic [SHAMT_W-1:0] shift_amt,
  input  logic [FIELD_W-1:0] imm_field,
  input  logic [2:0]         op_code,
  input  logic               set_flags,
  output logic [DATA_W-1:0]  result,
  output logic               result_we,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c,
  output logic               flag_v
);

  sol_op_e     op;
  sol_flags_t  flags_q;
  sol_flags_t  alu_flags;
  logic [DATA_W-1:0] sh_val, imm_val, op2, alu_res;
  logic sh_c, imm_c, op2_c, update;

  assign op     = sol_op_e'(op_code);
  assign update = set_flags || op_is_probe(op);

  sol_shifter #(.W(DATA_W), .SW(SHAMT_W)) u_shift (
    .din   (src_b),
    .kind  (sol_shift_e'(shift_kind)),
    .amt   (shift_amt),
    .c_in  (flags_q.c),
    .dout  (sh_val),
    .c_out (sh_c)
  );

  sol_imm_expand #(.W(DATA_W), .IW(IMM_W), .RW(ROT_W), .SW(SHAMT_W)) u_imm (
    .field (imm_field),
    .c_in  (flags_q.c),
    .value (imm_val),
    .c_out (imm_c)
  );

  assign op2   = use_imm ? imm_val : sh_val;
  assign op2_c = use_imm ? imm_c : sh_c;

  sol_alu #(.W(DATA_W)) u_alu (
    .a     (src_a),
    .b     (op2),
    .op    (op),
    .sh_c  (op2_c),
    .f_in  (flags_q),
    .res   (alu_res),
    .f_out (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_q   <= '0;
    end else begin
      result    <= alu_res;
      result_we <= !op_is_probe(op);
      if (update) flags_q <= alu_flags;
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // R7: probe opcodes never request a write
  assert_probe_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    op_is_probe(op) |=> !result_we);

  // R8: without a request the flags stay put
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !update |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R9: N and Z follow the registered result when flags load
  assert_nz_track_R9: assert property (@(posedge clk) disable iff (rst)
    update |=> (flag_n == result[DATA_W-1]) && (flag_z == (result == '0)));

  // R10: logical opcodes leave V alone
  assert_logic_v_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (update && !op_is_arith(op)) |=> $stable(flag_v));

endmodule

// File: tb/sol_unit_tb.sv
`timescale 1ns/1ps
module sol_unit_tb;

  localparam int W  = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  src_a = '0, src_b = '0;
  logic          use_imm = 1'b0;
  logic [1:0]    shift_kind = '0;
  logic [SW-1:0] shift_amt = '0;
  logic [11:0]   imm_field = '0;
  logic [2:0]    op_code = '0;
  logic          set_flags = 1'b0;
  logic [W-1:0]  result;
  logic          result_we, flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] mf = 4'b0; // model flags {n,z,c,v}

  always #2 clk = ~clk;

  sol_unit #(.DATA_W(W), .IMM_W(8), .ROT_W(4)) u_dut (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .use_imm(use_imm),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .imm_field(imm_field),
    .op_code(op_code), .set_flags(set_flags), .result(result),
    .result_we(result_we), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // bit-at-a-time shift model
  task automatic ref_shift(input logic [W-1:0] v_in, input int kind, input int amt,
                           input logic cin, output logic [W-1:0] v, output logic c);
    v = v_in;
    c = cin;
    for (int i = 0; i < amt; i++) begin
      case (kind)
        0: begin c = v[W-1]; v = {v[W-2:0], 1'b0}; end
        1: begin c = v[0];   v = {1'b0, v[W-1:1]}; end
        2: begin c = v[0];   v = {v[W-1], v[W-1:1]}; end
        default: begin c = v[0]; v = {v[0], v[W-1:1]}; end
      endcase
    end
  endtask

  task automatic ref_imm(input logic [11:0] f, input logic cin,
                         output logic [W-1:0] v, output logic c);
    v = f[7:0];
    for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[W-1:1]};
    c = (f[11:8] == 4'd0) ? cin : v[W-1];
  endtask

  task automatic step(input int op, input bit imm, input int kind, input int amt,
                      input logic [11:0] f, input logic [W-1:0] a,
                      input logic [W-1:0] b, input bit sf, input string rtag);
    logic [W-1:0] op2, er;
    logic sc, ec, ev, upd;
    logic [W:0] s;
    @(negedge clk);
    src_a = a; src_b = b; use_imm = imm; shift_kind = 2'(kind);
    shift_amt = SW'(amt); imm_field = f; op_code = 3'(op); set_flags = sf;
    if (imm) ref_imm(f, mf[1], op2, sc);
    else     ref_shift(b, kind, amt, mf[1], op2, sc);
    ec = sc; ev = mf[0];
    case (op)
      0, 7: er = a & op2;
      1: er = a | op2;
      2: er = a ^ op2;
      3: er = a & ~op2;
      4: begin
        s = {1'b0, a} + {1'b0, op2}; er = s[W-1:0]; ec = s[W];
        ev = (a[W-1] == op2[W-1]) && (er[W-1] != a[W-1]);
      end
      default: begin
        s = {1'b0, a} + {1'b0, ~op2} + 1; er = s[W-1:0]; ec = s[W];
        ev = (a[W-1] != op2[W-1]) && (er[W-1] != a[W-1]);
      end
    endcase
    upd = sf || op == 6 || op == 7;
    @(posedge clk);
    #1;
    check(result == er, rtag, "result", 32'(result), 32'(er));
    check(result_we == !(op == 6 || op == 7), "R7", "write enable",
          32'(result_we), 32'(!(op == 6 || op == 7)));
    if (upd) mf = {er[W-1], er == '0, ec, ev};
    check({flag_n, flag_z, flag_c, flag_v} == mf, "R8/R9/R10/R11", "flags",
          32'({flag_n, flag_z, flag_c, flag_v}), 32'(mf));
  endtask

  logic [W-1:0] pa [6] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h5A, 8'h01};
  logic [W-1:0] pb [6] = '{8'h00, 8'h01, 8'h01, 8'h81, 8'hC3, 8'hFF};

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({result, result_we, flag_n, flag_z, flag_c, flag_v} == '0, "R1",
          "reset state", 32'({result, result_we, flag_n, flag_z, flag_c, flag_v}), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2: bit-clear of 0xFF with 0xAA
    step(3, 0, 0, 0, 12'h0, 8'hFF, 8'hAA, 1, "R2");
    check(result == 8'h55, "R2", "bit-clear value", 32'(result), 32'h55);
    // R4: 4 >> 2 then >> 3
    step(1, 0, 1, 2, 12'h0, 8'h00, 8'h04, 0, "R4");
    check(result == 8'h01, "R4", "first shift", 32'(result), 32'h01);
    step(1, 0, 1, 3, 12'h0, 8'h00, result, 0, "R4");
    check(result == 8'h00, "R4", "second shift", 32'(result), 32'h00);
    // R7/R8: compare equal, then hold through an unflagged op
    step(6, 0, 0, 0, 12'h0, 8'h33, 8'h33, 0, "R6");
    check(flag_z && !result_we, "R7", "cmp equal", 32'({flag_z, result_we}), 32'h2);
    step(4, 0, 0, 0, 12'h0, 8'h01, 8'h01, 0, "R8");
    check(flag_z == 1'b1, "R8", "Z held", 32'(flag_z), 32'h1);

    // R2/R3/R6/R10/R11: all opcodes x shift types x amounts
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 4; k++)
        for (int am = 0; am < 8; am++)
          for (int p = 0; p < 6; p++)
            for (int sf = 0; sf < 2; sf++)
              step(op, 0, k, am, 12'h0, pa[p], pb[p], sf[0],
                   (op >= 4 && op <= 6) ? "R3/R6" : "R2/R3");

    // R5: every immediate field
    for (int f = 0; f < 4096; f++)
      step((f % 3 == 0) ? 4 : 1, 1, 0, 0, 12'(f), 8'((f * 7) & 8'hFF), 8'h00,
           1, "R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule